// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block sits above a serial switch-register master. It takes one PHY register request at a time and turns it into the series of 16-bit switch register transactions that indirect PHY access needs. A request carries a PHY number, a page, a register index, a direction and, for writes, a data word. The sequencer first checks the ranges. It then writes a direction word to a control register and makes an access at an address built from the PHY, page and register fields. For a read it also fetches a data register. It reports the outcome with a one-cycle done pulse, an error flag and 16 bits of read data.

The downstream master is reached through a request/response port. The sequencer holds one transaction on that port until the master answers with done, and that answer may carry an error. A request with the MDIO-style mode bit set behaves as a generic management bus access. The page is forced to zero. A write is followed by a flush read of the same register, and the result of that read is thrown away. A failed read returns all ones.

Top module: `phy_indirect_seq`

## Requirements
- R1: An accepted request with PHY number above 4, register index above 31, or (outside MDIO mode) page above 7 completes on the next cycle with err_o high and issues no bus transaction.
- R2: Every sequence and every flush pass opens with a write to the control address 0x8028. The data is 1 for a read pass and 0 for a write pass.
- R3: The access address is 0x8000 OR (1 << (PHY + 9)) OR (page << 5) OR register index, with the page in bits 7:5 and the register in bits 4:0.
- R4: A write sequence in plain mode is the control write followed by a write of req_wdata_i to the access address, and nothing else.
- R5: A read sequence writes 0 to the access address and then reads address 0x8029. The returned word appears on rdata_o when done_o pulses.
- R6: In plain mode, a bus response with an error ends the sequence at once with err_o high and no further bus transaction. rdata_o is then 0.
- R7: In MDIO mode a write is followed by a flush read pass (control 1, access write 0, data read). The flush pass runs even if the write pass failed. Its data and its errors do not affect rdata_o (0) or err_o.
- R8: In MDIO mode the page input is ignored. The access address carries page 0, and a page above 7 is not an error.
- R9: In MDIO mode a failed read, including a range failure, returns rdata_o = 0xFFFF with err_o high.
- R10: Only one request is outstanding. req_ready_o is low from acceptance until done_o, and requests offered meanwhile are ignored. done_o lasts one cycle, and rdata_o and err_o hold until the next acceptance. A bus request stays stable until bus_done_i.
- R11: After reset the block is idle: req_ready_o high, bus_valid_o low, done_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Idle, request accepted this cycle if valid |
| req_write_i | input | 1 | 1 write, 0 read |
| req_mdio_i | input | 1 | MDIO-style mode: page 0, flush after write, 0xFFFF on failed read |
| req_phy_i | input | 5 | PHY number |
| req_page_i | input | 4 | Page |
| req_reg_i | input | 6 | Register index |
| req_wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion had an error |
| rdata_o | output | 16 | Read result |
| bus_valid_o | output | 1 | Switch register transaction pending |
| bus_write_o | output | 1 | Transaction is a write |
| bus_addr_o | output | 16 | Switch register address |
| bus_wdata_o | output | 16 | Switch register write data |
| bus_done_i | input | 1 | Transaction finished (one cycle) |
| bus_err_i | input | 1 | Finished transaction failed, valid with bus_done_i |
| bus_rdata_i | input | 16 | Read data, valid with bus_done_i |

## Verification
The assertions assume the downstream master raises bus_done_i only while bus_valid_o is high, for one cycle per transaction. They also assume bus_err_i and bus_rdata_i matter only in that cycle. The bench bus model keeps to this: it answers each held transaction after a fixed latency with a single-cycle pulse. It logs every transaction and injects an error at a chosen transaction index. Requests offered while the block is busy are withdrawn before the sequence ends, so they are never accepted late.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_DONE} seq_state_e;
  typedef enum logic [1:0] {STEP_CTRL, STEP_ACC, STEP_DATA} seq_step_e;
endpackage

// File: rtl/phy_acc_encode.sv
module phy_acc_encode #(
  parameter int PHY_W      = 5,
  parameter int PAGE_W     = 4,
  parameter int REG_W      = 6,
  parameter int AW         = 16,
  parameter int PHY_MAX    = 4,
  parameter int PAGE_MAX   = 7,
  parameter int REG_MAX    = 31,
  parameter int PHY_SHIFT  = 9,
  parameter int PAGE_SHIFT = 5,
  parameter int PAGE_FW    = 3,
  parameter int REG_FW     = 5,
  parameter logic [AW-1:0] ACC_BASE = 16'h8000
) (
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic              page_zero_i,
  output logic              ok_o,
  output logic [AW-1:0]     addr_o
);
  localparam int NPHY = PHY_MAX + 1;

  logic [NPHY-1:0]   phy_sel;
  logic [PAGE_W-1:0] page_eff;

  for (genvar i = 0; i < NPHY; i++) begin : g_sel
    assign phy_sel[i] = (phy_i == PHY_W'(i));
  end

  assign page_eff = page_zero_i ? '0 : page_i;

  assign ok_o = (phy_i <= PHY_W'(PHY_MAX)) &&
                (page_zero_i || (page_i <= PAGE_W'(PAGE_MAX))) &&
                (reg_i <= REG_W'(REG_MAX));

  assign addr_o = ACC_BASE
                | (AW'(phy_sel) << PHY_SHIFT)
                | (AW'(page_eff[PAGE_FW-1:0]) << PAGE_SHIFT)
                | AW'(reg_i[REG_FW-1:0]);
endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      bad_i,
  input  logic      write_i,    // direction of the accepted request
  input  logic      write_q_i,  // latched direction
  input  logic      flush_en_i, // latched mdio mode
  input  logic      bus_done_i,
  input  logic      bus_err_i,
  output seq_state_e state_o,
  output seq_step_e  step_o,
  output logic      pass_rd_o,
  output logic      err_o,
  output logic      cap_o
);
  seq_state_e state_q;
  seq_step_e  step_q;
  logic       pass_rd_q, flush_q, err_q;

  assign state_o   = state_q;
  assign step_o    = step_q;
  assign pass_rd_o = pass_rd_q;
  assign err_o     = err_q;
  assign cap_o     = (state_q == ST_BUS) && bus_done_i && !bus_err_i &&
                     (step_q == STEP_DATA) && !flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      step_q    <= STEP_CTRL;
      pass_rd_q <= 1'b0;
      flush_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          flush_q   <= 1'b0;
          step_q    <= STEP_CTRL;
          pass_rd_q <= !write_i;
          if (bad_i) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            err_q   <= 1'b0;
            state_q <= ST_BUS;
          end
        end
        ST_BUS: if (bus_done_i) begin
          if (bus_err_i) begin
            if (flush_q) state_q <= ST_DONE;
            else begin
              err_q <= 1'b1;
              if (write_q_i && flush_en_i) begin
                flush_q   <= 1'b1;
                pass_rd_q <= 1'b1;
                step_q    <= STEP_CTRL;
              end else state_q <= ST_DONE;
            end
          end else begin
            unique case (step_q)
              STEP_CTRL: step_q <= STEP_ACC;
              STEP_ACC: begin
                if (pass_rd_q) step_q <= STEP_DATA;
                else if (flush_en_i) begin
                  flush_q   <= 1'b1;
                  pass_rd_q <= 1'b1;
                  step_q    <= STEP_CTRL;
                end else state_q <= ST_DONE;
              end
              default: state_q <= ST_DONE;
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: a sequence never re-enters the bus state straight from done
  assert_done_to_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DONE |=> state_q == ST_IDLE);
endmodule

// File: rtl/phy_bus_mux.sv
module phy_bus_mux
  import phy_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h8028,
  parameter logic [AW-1:0] DATA_ADDR = 16'h8029
) (
  input  seq_step_e       step_i,
  input  logic            pass_rd_i,
  input  logic [AW-1:0]   acc_addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [AW-1:0]   addr_o,
  output logic            write_o,
  output logic [DW-1:0]   wdata_o
);
  always_comb begin
    unique case (step_i)
      STEP_CTRL: begin
        addr_o  = CTRL_ADDR;
        write_o = 1'b1;
        wdata_o = DW'(pass_rd_i);
      end
      STEP_ACC: begin
        addr_o  = acc_addr_i;
        write_o = 1'b1;
        wdata_o = pass_rd_i ? '0 : wdata_i;
      end
      default: begin
        addr_o  = DATA_ADDR;
        write_o = 1'b0;
        wdata_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/phy_indirect_seq.sv
module phy_indirect_seq
  import phy_seq_pkg::*;
#(
  parameter int PHY_W      = 5,
  parameter int PAGE_W     = 4,
  parameter int REG_W      = 6,
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int PHY_MAX    = 4,
  parameter int PAGE_MAX   = 7,
  parameter int REG_MAX    = 31,
  parameter int PHY_SHIFT  = 9,
  parameter int PAGE_SHIFT = 5,
  parameter logic [AW-1:0] ACC_BASE  = 16'h8000,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h8028,
  parameter logic [AW-1:0] DATA_ADDR = 16'h8029
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_mdio_i,
  input  logic [PHY_W-1:0]  req_phy_i,
  input  logic [PAGE_W-1:0] req_page_i,
  input  logic [REG_W-1:0]  req_reg_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DW-1:0]     rdata_o,
  output logic              bus_valid_o,
  output logic              bus_write_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic              bus_done_i,
  input  logic              bus_err_i,
  input  logic [DW-1:0]     bus_rdata_i
);
  localparam int NPHY    = PHY_MAX + 1;
  localparam int PAGE_FW = $clog2(PAGE_MAX + 1);
  localparam int REG_FW  = $clog2(REG_MAX + 1);

  seq_state_e state;
  seq_step_e  step;
  logic       pass_rd, seq_err, cap, accept, enc_ok;
  logic [AW-1:0] enc_addr, acc_addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          write_q, mdio_q;

  assign accept = req_valid_i && req_ready_o;

  phy_acc_encode #(
    .PHY_W(PHY_W), .PAGE_W(PAGE_W), .REG_W(REG_W), .AW(AW),
    .PHY_MAX(PHY_MAX), .PAGE_MAX(PAGE_MAX), .REG_MAX(REG_MAX),
    .PHY_SHIFT(PHY_SHIFT), .PAGE_SHIFT(PAGE_SHIFT),
    .PAGE_FW(PAGE_FW), .REG_FW(REG_FW), .ACC_BASE(ACC_BASE)
  ) u_enc (
    .phy_i(req_phy_i), .page_i(req_page_i), .reg_i(req_reg_i),
    .page_zero_i(req_mdio_i), .ok_o(enc_ok), .addr_o(enc_addr)
  );

  phy_seq_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(accept), .bad_i(!enc_ok), .write_i(req_write_i),
    .write_q_i(write_q), .flush_en_i(mdio_q),
    .bus_done_i(bus_done_i), .bus_err_i(bus_err_i),
    .state_o(state), .step_o(step), .pass_rd_o(pass_rd),
    .err_o(seq_err), .cap_o(cap)
  );

  phy_bus_mux #(
    .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_mux (
    .step_i(step), .pass_rd_i(pass_rd), .acc_addr_i(acc_addr_q),
    .wdata_i(wdata_q), .addr_o(bus_addr_o), .write_o(bus_write_o),
    .wdata_o(bus_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_addr_q <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      write_q    <= 1'b0;
      mdio_q     <= 1'b0;
    end else if (accept) begin
      acc_addr_q <= enc_addr;
      wdata_q    <= req_wdata_i;
      rdata_q    <= '0;
      write_q    <= req_write_i;
      mdio_q     <= req_mdio_i;
    end else if (cap) begin
      rdata_q <= bus_rdata_i;
    end
  end

  assign req_ready_o = (state == ST_IDLE);
  assign bus_valid_o = (state == ST_BUS);
  assign done_o      = (state == ST_DONE);
  assign err_o       = seq_err;
  assign rdata_o     = (seq_err && mdio_q && !write_q) ? '1 : rdata_q;

  assert_range_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !enc_ok |=> done_o && err_o && !bus_valid_o);

  assert_ctrl_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_valid_o) |-> bus_addr_o == CTRL_ADDR && bus_write_o &&
                           bus_wdata_o[DW-1:1] == '0);

  assert_acc_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && step == STEP_ACC |->
      bus_addr_o[AW-1] && $onehot(bus_addr_o[PHY_SHIFT +: NPHY]));

  assert_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_done_i && bus_err_i && !(mdio_q && write_q) |=> !bus_valid_o);

  assert_mdio_page0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && step == STEP_ACC && mdio_q |->
      bus_addr_o[PAGE_SHIFT +: PAGE_FW] == '0);

  assert_bus_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_done_i |=> bus_valid_o && $stable(bus_addr_o) &&
                                   $stable(bus_write_o) && $stable(bus_wdata_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && $stable(rdata_o) && $stable(err_o));
endmodule

// File: tb/sim_phy_indirect_seq.sv
module sim_phy_indirect_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CTRL = 16'h8028;
  localparam logic [15:0] DATA = 16'h8029;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid = 0, req_write = 0, req_mdio = 0;
  logic [4:0] req_phy = 0;
  logic [3:0] req_page = 0;
  logic [5:0] req_reg = 0;
  logic [15:0] req_wdata = 0;
  logic req_ready, done, err, bus_valid, bus_write;
  logic [15:0] rdata, bus_addr, bus_wdata;
  logic bus_done, bus_err;
  logic [15:0] rd_val = 0;
  int fail_at = -1;
  logic log_clr = 0;

  phy_indirect_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_mdio_i(req_mdio), .req_phy_i(req_phy), .req_page_i(req_page),
    .req_reg_i(req_reg), .req_wdata_i(req_wdata),
    .done_o(done), .err_o(err), .rdata_o(rdata),
    .bus_valid_o(bus_valid), .bus_write_o(bus_write), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_done_i(bus_done), .bus_err_i(bus_err),
    .bus_rdata_i(rd_val)
  );

  // bus model: answers each held transaction after two cycles, logs it
  int ntx, wcnt;
  logic [15:0] log_addr [16];
  logic        log_wr   [16];
  logic [15:0] log_wd   [16];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntx <= 0; wcnt <= 0; bus_done <= 0; bus_err <= 0;
    end else begin
      if (log_clr) ntx <= 0;
      if (bus_done) begin
        bus_done <= 0; bus_err <= 0;
      end else if (bus_valid) begin
        if (wcnt == 1) begin
          bus_done <= 1;
          bus_err  <= (ntx == fail_at);
          if (ntx < 16) begin
            log_addr[ntx] <= bus_addr; log_wr[ntx] <= bus_write; log_wd[ntx] <= bus_wdata;
          end
          ntx  <= ntx + 1;
          wcnt <= 0;
        end else wcnt <= wcnt + 1;
      end
    end
  end

  int checks = 0, failures = 0, cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  logic [15:0] e_addr [16];
  logic        e_wr   [16];
  logic [15:0] e_wd   [16];
  int e_n;
  task automatic push(input logic [15:0] a, input logic w, input logic [15:0] d);
    e_addr[e_n] = a; e_wr[e_n] = w; e_wd[e_n] = d; e_n++;
  endtask

  function automatic logic [15:0] enc(input int phy, input int pg, input int rg);
    return 16'h8000 | (16'h1 << (phy + 9)) | 16'(pg << 5) | 16'(rg);
  endfunction

  task automatic run(input string tag, input bit wr, input bit md, input int phy, input int pg,
                     input int rg, input logic [15:0] wd, input int fat, input logic [15:0] rv,
                     input bit exp_err, input logic [15:0] exp_rd, input bit busy_poke);
    @(negedge clk); log_clr = 1; fail_at = fat; rd_val = rv;
    @(negedge clk); log_clr = 0;
    req_write = wr; req_mdio = md; req_phy = 5'(phy); req_page = 4'(pg);
    req_reg = 6'(rg); req_wdata = wd; req_valid = 1;
    @(negedge clk); req_valid = 0;
    if (busy_poke) begin
      chk(!req_ready, {tag, " R10 ready low while busy"}, 32'(req_ready), 0);
      req_valid = 1; req_write = ~wr; req_phy = 5'd0; req_reg = 6'd1; req_wdata = 16'hDEAD;
      repeat (3) @(negedge clk);
      req_valid = 0;
    end
    for (int n = 0; n < 300 && !done; n++) @(negedge clk);
    chk(done, {tag, " done seen"}, 32'(done), 1);
    chk(err == exp_err, {tag, " err"}, 32'(err), 32'(exp_err));
    chk(rdata == exp_rd, {tag, " rdata"}, 32'(rdata), 32'(exp_rd));
    @(negedge clk);
    chk(!done && req_ready && rdata == exp_rd && err == exp_err,
        {tag, " R10 done one cycle, result held"}, {15'(0), done, rdata}, {16'h0, exp_rd});
    chk(ntx == e_n, {tag, " transaction count"}, 32'(ntx), 32'(e_n));
    for (int i = 0; i < e_n && i < ntx; i++)
      chk(log_addr[i] == e_addr[i] && log_wr[i] == e_wr[i] && (!e_wr[i] || log_wd[i] == e_wd[i]),
          $sformatf("%s tx%0d", tag, i), {log_addr[i], log_wd[i]}, {e_addr[i], e_wd[i]});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready && !bus_valid && !done, "R11 reset idle", {req_ready, bus_valid, done}, 3'b100);
  endtask

  task automatic t_read_plain; // R2 R3 R5
    e_n = 0;
    push(CTRL, 1, 16'h0001); push(enc(2, 3, 17), 1, 16'h0000); push(DATA, 0, 0);
    chk(enc(2, 3, 17) == 16'h8871, "R3 encoding reference", 32'(enc(2, 3, 17)), 32'h8871);
    run("R5 plain read", 0, 0, 2, 3, 17, 16'h0, -1, 16'hBEEF, 0, 16'hBEEF, 1);
  endtask

  task automatic t_write_plain; // R2 R3 R4
    e_n = 0;
    push(CTRL, 1, 16'h0000); push(16'hA0FF, 1, 16'h1234);
    run("R4 plain write max fields", 1, 0, 4, 7, 31, 16'h1234, -1, 16'h5555, 0, 16'h0, 0);
  endtask

  task automatic t_range; // R1
    e_n = 0;
    run("R1 phy 5", 0, 0, 5, 0, 0, 16'h0, -1, 16'h1, 1, 16'h0, 0);
    run("R1 page 8", 1, 0, 0, 8, 0, 16'h9, -1, 16'h1, 1, 16'h0, 0);
    run("R1 reg 32", 0, 0, 1, 0, 32, 16'h0, -1, 16'h1, 1, 16'h0, 0);
  endtask

  task automatic t_abort; // R6
    e_n = 0;
    push(CTRL, 1, 16'h0001); push(enc(3, 1, 2), 1, 16'h0);
    run("R6 abort on access", 0, 0, 3, 1, 2, 16'h0, 1, 16'hCAFE, 1, 16'h0, 0);
  endtask

  task automatic t_mdio_write; // R7 R8
    e_n = 0;
    push(CTRL, 1, 16'h0000); push(16'h8404, 1, 16'hA5A5);
    push(CTRL, 1, 16'h0001); push(16'h8404, 1, 16'h0000); push(DATA, 0, 0);
    run("R7 R8 mdio write flush", 1, 1, 1, 5, 4, 16'hA5A5, -1, 16'h7777, 0, 16'h0, 0);
  endtask

  task automatic t_mdio_write_fail; // R7
    e_n = 0;
    push(CTRL, 1, 16'h0000);
    push(CTRL, 1, 16'h0001); push(enc(0, 0, 9), 1, 16'h0000); push(DATA, 0, 0);
    run("R7 flush after failed write", 1, 1, 0, 0, 9, 16'h1111, 0, 16'h2222, 1, 16'h0, 0);
    e_n = 0;
    push(CTRL, 1, 16'h0000); push(enc(0, 0, 9), 1, 16'h3333);
    push(CTRL, 1, 16'h0001); push(enc(0, 0, 9), 1, 16'h0000);
    run("R7 flush error ignored", 1, 1, 0, 0, 9, 16'h3333, 3, 16'h2222, 0, 16'h0, 0);
  endtask

  task automatic t_mdio_read; // R8 R9
    e_n = 0;
    push(CTRL, 1, 16'h0001); push(enc(4, 0, 1), 1, 16'h0); push(DATA, 0, 0);
    run("R8 mdio read page ignored", 0, 1, 4, 12, 1, 16'h0, -1, 16'h0102, 0, 16'h0102, 0);
    e_n = 0;
    push(CTRL, 1, 16'h0001); push(enc(4, 0, 1), 1, 16'h0); push(DATA, 0, 0);
    run("R9 mdio failed read", 0, 1, 4, 3, 1, 16'h0, 2, 16'h0102, 1, 16'hFFFF, 0);
    e_n = 0;
    run("R9 mdio range fail", 0, 1, 6, 0, 1, 16'h0, -1, 16'h0, 1, 16'hFFFF, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read_plain();
    t_write_plain();
    t_range();
    t_abort();
    t_mdio_write();
    t_mdio_write_fail();
    t_mdio_read();
    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule